// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC receive deframer that has already removed flags and bit-stuffing. It takes a byte stream marked with start-of-frame and end-of-frame, together with the deframer's CRC verdict and abort indication. A mode selection decides, frame by frame, whether the frame reaches the receive FIFO, which bytes are written, and which header bytes are latched into two readable capture registers: a low-address register and a control-field register. The receive FIFO is modelled as a single byte-write output. Each accepted framed frame is followed by one appended status byte.

Address comparison looks at the first byte of a frame. It tests that byte against two programmable values, a fixed broadcast value and a fixed group value. A per-bit mask can exclude chosen bits from the test. Two extended transparent modes bypass framing completely: a raw byte-valid input feeds the low-address register and, in one sub-mode, the FIFO.

The mode input is taken into account only when a frame starts, so changing it while a frame is arriving has no effect on that frame. The deframer leaves at least one idle cycle after every end-of-frame byte, because the closing flag takes eight bit times.

Top module: `hdlc_addr_filter`

## Requirements
- R1: The mode is decoded from `mode_sel` and `addr_mode`: `mode_sel`=01 selects address recognition; 10 selects transparent mode 0 when `addr_mode`=0 and transparent mode 1 when `addr_mode`=1; 11 selects extended transparent mode, with sub-mode 0 when `addr_mode`=0 and sub-mode 1 when `addr_mode`=1. With `mode_sel`=00, framed input is ignored: there are no FIFO writes and no capture.
- R2: In address-recognition mode, an accepted frame writes every byte after the first (address) byte to the FIFO in order, then writes one status byte.
- R3: In address-recognition mode, the second byte of an accepted frame is latched into `ctrl_field`.
- R4: The first byte matches if it equals `prog_addr1` (code 00), `prog_addr2` (code 01), the broadcast value BCAST_VAL (code 10, default 0xFE) or the group value GROUP_VAL (code 11, default 0xFC). When several match, the lowest code is reported.
- R5: In transparent mode 1, the first byte of an accepted frame is not written and every later byte is written. The second byte is latched into `low_addr` and the third byte into `ctrl_field`.
- R6: In transparent mode 0, every frame is accepted and every byte is written, with match code 00 in the status byte. The first byte is latched into `low_addr` and the second into `ctrl_field`.
- R7: In extended transparent sub-mode 0, each `raw_valid` byte is loaded into `low_addr` on the next cycle, and nothing is written to the FIFO.
- R8: In extended transparent sub-mode 1, each `raw_valid` byte is also written to the FIFO on the next cycle.
- R9: A bit set to 1 in `addr_mask` is ignored in every address comparison.
- R10: A frame whose first byte matches nothing (in address-recognition or transparent mode 1) produces no FIFO write and no status byte, and it leaves `low_addr` and `ctrl_field` unchanged.
- R11: The status byte has bit 7 = the CRC-ok input of the end byte, bit 6 = the abort input of the end byte, bits 5:2 = 0, and bits 1:0 = the match code. A data byte is written one cycle after it is presented; the status byte follows one cycle after the last data byte.
- R12: The mode is sampled at start-of-frame. A mode change during a frame does not alter how that frame is handled.
- R13: After reset, `fifo_wr` is 0 and `low_addr` and `ctrl_field` are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Receive mode field |
| addr_mode | input | 1 | Address-mode bit (sub-mode select) |
| prog_addr1 | input | 8 | First programmable address compare value |
| prog_addr2 | input | 8 | Second programmable address compare value |
| addr_mask | input | 8 | Per-bit compare mask, 1 = ignore bit |
| in_valid | input | 1 | Deframed byte valid |
| in_data | input | 8 | Deframed byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_crc_ok | input | 1 | CRC verdict, qualified by in_eof |
| in_abort | input | 1 | Abort indication, qualified by in_eof |
| raw_valid | input | 1 | Raw assembled byte valid (extended modes) |
| raw_data | input | 8 | Raw assembled byte |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | 8 | Receive FIFO write byte |
| low_addr | output | 8 | Low-address capture register |
| ctrl_field | output | 8 | Control-field capture register |

## Verification
The bench builds the block with its default compare constants: broadcast 0xFE, group 0xFC, and a two-bit saturating byte-index counter. With these values, each of the four match codes can be reached from real frame bytes. The counter width is the smallest that still tells apart the first, second and third byte positions used by the capture rules. A nonzero mask then lets a programmable value match a byte that differs from it only in masked bits. A single-byte frame reaches the status-only path.

// File: rtl/hdlc_rxf_pkg.sv
package hdlc_rxf_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_REF = 4;
    localparam int CODE_W  = $clog2(NUM_REF);

    typedef enum logic [2:0] {
        FM_IDLE,
        FM_ADDR,
        FM_TR0,
        FM_TR1,
        FM_EXT0,
        FM_EXT1
    } rx_mode_e;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } match_t;

    typedef struct packed {
        logic              crc_ok;
        logic              aborted;
        logic [3:0]        zero;
        logic [CODE_W-1:0] code;
    } status_t;

    function automatic rx_mode_e decode_mode(input logic [1:0] sel, input logic am);
        case (sel)
            2'b01:   return FM_ADDR;
            2'b10:   return am ? FM_TR1 : FM_TR0;
            2'b11:   return am ? FM_EXT1 : FM_EXT0;
            default: return FM_IDLE;
        endcase
    endfunction

    function automatic logic is_framed(input rx_mode_e m);
        return (m == FM_ADDR) || (m == FM_TR0) || (m == FM_TR1);
    endfunction

    function automatic logic needs_addr(input rx_mode_e m);
        return (m == FM_ADDR) || (m == FM_TR1);
    endfunction

    function automatic logic masked_eq(input logic [BYTE_W-1:0] a,
                                       input logic [BYTE_W-1:0] b,
                                       input logic [BYTE_W-1:0] dont_care);
        return ((a ^ b) & ~dont_care) == '0;
    endfunction

endpackage

// File: rtl/hdlc_rxf_match.sv
module hdlc_rxf_match
    import hdlc_rxf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BCAST_VAL = 8'hFE,
    parameter logic [BYTE_W-1:0] GROUP_VAL = 8'hFC
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] ref_a,
    input  logic [BYTE_W-1:0] ref_b,
    input  logic [BYTE_W-1:0] mask,
    output match_t            result
);

    logic [BYTE_W-1:0] refs [NUM_REF];
    logic [NUM_REF-1:0] hits;

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = BCAST_VAL;
    assign refs[3] = GROUP_VAL;

    for (genvar g = 0; g < NUM_REF; g++) begin : g_cmp
        assign hits[g] = masked_eq(byte_in, refs[g], mask);
    end

    always_comb begin
        result = '0;
        for (int i = NUM_REF - 1; i >= 0; i--) begin
            if (hits[i]) begin
                result.hit  = 1'b1;
                result.code = CODE_W'(i);
            end
        end
    end

endmodule

// File: rtl/hdlc_rxf_seq.sv
module hdlc_rxf_seq
    import hdlc_rxf_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_mode_e          mode,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_crc_ok,
    input  logic              in_abort,
    input  match_t            mt,
    output logic              req_wr,
    output logic [BYTE_W-1:0] req_data,
    output logic              cap_low,
    output logic              cap_ctl,
    output logic              busy,
    output logic              pend
);

    localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};

    rx_mode_e          fmode_q;
    logic              in_frame_q, acc_q, pend_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CODE_W-1:0] code_q;
    status_t           stat_q;

    logic              start, live, cur_acc, take, hdr_drop;
    rx_mode_e          cur_mode;
    logic [CNT_W-1:0]  cur_idx, nxt_idx;
    logic [CODE_W-1:0] cur_code;
    status_t           stat_d;

    always_comb begin
        start    = in_valid && in_sof && is_framed(mode);
        live     = start || (in_valid && in_frame_q);
        cur_mode = start ? mode : fmode_q;
        cur_idx  = start ? '0 : idx_q;
        nxt_idx  = (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
        cur_acc  = start ? (needs_addr(mode) ? mt.hit : 1'b1) : acc_q;
        cur_code = start ? (needs_addr(mode) ? mt.code : '0) : code_q;
        take     = live && cur_acc;
        hdr_drop = needs_addr(cur_mode) && (cur_idx == '0);

        cap_low  = take && (((cur_mode == FM_TR1) && (cur_idx == CNT_W'(1))) ||
                            ((cur_mode == FM_TR0) && (cur_idx == '0)));
        cap_ctl  = take && (((cur_mode == FM_ADDR) && (cur_idx == CNT_W'(1))) ||
                            ((cur_mode == FM_TR1)  && (cur_idx == CNT_W'(2))) ||
                            ((cur_mode == FM_TR0)  && (cur_idx == CNT_W'(1))));

        stat_d.crc_ok  = in_crc_ok;
        stat_d.aborted = in_abort;
        stat_d.zero    = '0;
        stat_d.code    = cur_code;

        req_wr   = pend_q || (take && !hdr_drop);
        req_data = pend_q ? stat_q : in_data;
        busy     = in_frame_q || pend_q;
        pend     = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmode_q    <= FM_IDLE;
            in_frame_q <= 1'b0;
            acc_q      <= 1'b0;
            pend_q     <= 1'b0;
            idx_q      <= '0;
            code_q     <= '0;
            stat_q     <= '0;
        end else begin
            pend_q <= live && in_eof && cur_acc;
            if (live) begin
                in_frame_q <= !in_eof;
                idx_q      <= nxt_idx;
                if (in_eof) stat_q <= stat_d;
            end
            if (start) begin
                fmode_q <= mode;
                acc_q   <= cur_acc;
                code_q  <= cur_code;
            end
        end
    end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_rxf_pkg::*;
#(
    parameter logic [7:0] BCAST_VAL = 8'hFE,
    parameter logic [7:0] GROUP_VAL = 8'hFC,
    parameter int         CNT_W     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       addr_mode,
    input  logic [7:0] prog_addr1,
    input  logic [7:0] prog_addr2,
    input  logic [7:0] addr_mask,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_crc_ok,
    input  logic       in_abort,
    input  logic       raw_valid,
    input  logic [7:0] raw_data,
    output logic       fifo_wr,
    output logic [7:0] fifo_data,
    output logic [7:0] low_addr,
    output logic [7:0] ctrl_field
);

    rx_mode_e          mode_now;
    match_t            mt;
    logic              req_wr, cap_low, cap_ctl, busy, pend;
    logic [BYTE_W-1:0] req_data;
    logic              ext_take;

    assign mode_now = decode_mode(mode_sel, addr_mode);
    assign ext_take = raw_valid && !busy &&
                      ((mode_now == FM_EXT0) || (mode_now == FM_EXT1));

    hdlc_rxf_match #(
        .BCAST_VAL(BCAST_VAL),
        .GROUP_VAL(GROUP_VAL)
    ) u_match (
        .byte_in(in_data),
        .ref_a  (prog_addr1),
        .ref_b  (prog_addr2),
        .mask   (addr_mask),
        .result (mt)
    );

    hdlc_rxf_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_now),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_crc_ok(in_crc_ok),
        .in_abort (in_abort),
        .mt       (mt),
        .req_wr   (req_wr),
        .req_data (req_data),
        .cap_low  (cap_low),
        .cap_ctl  (cap_ctl),
        .busy     (busy),
        .pend     (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            low_addr   <= '0;
            ctrl_field <= '0;
        end else begin
            fifo_wr   <= req_wr || (ext_take && (mode_now == FM_EXT1));
            fifo_data <= req_wr ? req_data : raw_data;
            if (cap_low)       low_addr <= in_data;
            else if (ext_take) low_addr <= raw_data;
            if (cap_ctl)       ctrl_field <= in_data;
        end
    end

endmodule

// File: rtl/hdlc_rxf_checker.sv
module hdlc_rxf_checker
    import hdlc_rxf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input rx_mode_e   mode_now,
    input logic       busy,
    input logic       pend,
    input logic       hit,
    input logic       in_valid,
    input logic       in_sof,
    input logic       raw_valid,
    input logic [7:0] raw_data,
    input logic       fifo_wr,
    input logic [7:0] fifo_data,
    input logic [7:0] low_addr,
    input logic [7:0] ctrl_field
);

    AST_EXT_LOW_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !busy && (mode_now == FM_EXT0 || mode_now == FM_EXT1))
        |=> low_addr == $past(raw_data)); // R7

    AST_EXT0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !busy && mode_now == FM_EXT0) |=> !fifo_wr); // R7

    AST_EXT1_WRITE: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !busy && mode_now == FM_EXT1)
        |=> (fifo_wr && fifo_data == $past(raw_data))); // R8

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && !pend && !hit &&
         (mode_now == FM_ADDR || mode_now == FM_TR1))
        |=> (!fifo_wr && $stable(low_addr) && $stable(ctrl_field))); // R10

    AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_now == FM_IDLE && !busy) |=> !fifo_wr); // R1

    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        pend |=> fifo_wr); // R11

endmodule

bind hdlc_addr_filter hdlc_rxf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_now  (mode_now),
    .busy      (busy),
    .pend      (pend),
    .hit       (mt.hit),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .raw_valid (raw_valid),
    .raw_data  (raw_data),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .low_addr  (low_addr),
    .ctrl_field(ctrl_field)
);

// File: tb/hdlc_addr_filter_bench.sv
module hdlc_addr_filter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       addr_mode = 1'b0;
    logic [7:0] prog_addr1 = 8'h40, prog_addr2 = 8'h70, addr_mask = 8'h00;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic       in_crc_ok = 1'b0, in_abort = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       raw_valid = 1'b0;
    logic [7:0] raw_data = 8'h00;
    logic       fifo_wr;
    logic [7:0] fifo_data, low_addr, ctrl_field;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;
    logic [7:0] got[$];

    always #2 clk = ~clk;

    hdlc_addr_filter u_hdlc_addr_filter (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr_mode(addr_mode),
        .prog_addr1(prog_addr1), .prog_addr2(prog_addr2), .addr_mask(addr_mask),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_crc_ok(in_crc_ok), .in_abort(in_abort),
        .raw_valid(raw_valid), .raw_data(raw_data),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .low_addr(low_addr), .ctrl_field(ctrl_field)
    );

    always @(negedge clk) if (!rst && fifo_wr) got.push_back(fifo_data);

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b[8], input int n, input logic ok,
                              input logic ab, input logic swap);
        got.delete();
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = b[i];
            in_sof = (i == 0); in_eof = (i == n - 1);
            in_crc_ok = ok; in_abort = ab;
            @(posedge clk); #1;
            if (swap && i == 0) begin mode_sel = 2'b01; addr_mode = 1'b0; end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic expect_q(input string req, input logic [7:0] e[8], input int n);
        chk({req, " write count"}, got.size(), n);
        for (int i = 0; i < n && i < got.size(); i++)
            chk({req, " write byte"}, got[i], e[i]);
    endtask

    task automatic t_reset();
        chk("R13 fifo_wr", fifo_wr, 0);
        chk("R13 low_addr", low_addr, 0);
        chk("R13 ctrl_field", ctrl_field, 0);
    endtask

    task automatic t_addr_accept();
        mode_sel = 2'b01; addr_mode = 1'b0;
        send_frame('{8'h40, 8'h13, 8'hAA, 8'hBB, 0, 0, 0, 0}, 4, 1'b1, 1'b0, 1'b0);
        expect_q("R2/R11 addr frame", '{8'h13, 8'hAA, 8'hBB, 8'h80, 0, 0, 0, 0}, 4);
        chk("R3 ctrl_field", ctrl_field, 8'h13);
    endtask

    task automatic t_addr_reject();
        send_frame('{8'h55, 8'h66, 8'h77, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b0);
        chk("R10 reject writes", got.size(), 0);
        chk("R10 ctrl kept", ctrl_field, 8'h13);
        chk("R10 low kept", low_addr, 8'h00);
    endtask

    task automatic t_tr1_bcast();
        mode_sel = 2'b10; addr_mode = 1'b1;
        send_frame('{8'hFE, 8'h21, 8'h03, 8'h99, 0, 0, 0, 0}, 4, 1'b1, 1'b0, 1'b0);
        expect_q("R4/R5 tr1 bcast", '{8'h21, 8'h03, 8'h99, 8'h82, 0, 0, 0, 0}, 4);
        chk("R5 low_addr", low_addr, 8'h21);
        chk("R5 ctrl_field", ctrl_field, 8'h03);
    endtask

    task automatic t_tr1_group_abort();
        send_frame('{8'hFC, 8'h31, 8'h05, 0, 0, 0, 0, 0}, 3, 1'b0, 1'b1, 1'b0);
        expect_q("R4/R11 group abort", '{8'h31, 8'h05, 8'h43, 0, 0, 0, 0, 0}, 3);
    endtask

    task automatic t_mask();
        addr_mask = 8'h0F;
        send_frame('{8'h7A, 8'h44, 8'h55, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b0);
        expect_q("R9 masked prog2", '{8'h44, 8'h55, 8'h81, 0, 0, 0, 0, 0}, 3);
        addr_mask = 8'h00;
        send_frame('{8'h7A, 8'h46, 8'h57, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b0);
        chk("R9 unmasked reject", got.size(), 0);
        chk("R10 low kept after reject", low_addr, 8'h44);
    endtask

    task automatic t_tr0();
        mode_sel = 2'b10; addr_mode = 1'b0;
        send_frame('{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b0);
        expect_q("R6 tr0 frame", '{8'h11, 8'h22, 8'h33, 8'h80, 0, 0, 0, 0}, 3 + 1);
        chk("R6 low_addr", low_addr, 8'h11);
        chk("R6 ctrl_field", ctrl_field, 8'h22);
    endtask

    task automatic t_mode_change();
        mode_sel = 2'b10; addr_mode = 1'b0;
        send_frame('{8'h09, 8'h0A, 8'h0B, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b1);
        expect_q("R12 mode held", '{8'h09, 8'h0A, 8'h0B, 8'h80, 0, 0, 0, 0}, 4);
        chk("R12 low_addr", low_addr, 8'h09);
    endtask

    task automatic t_single_byte();
        mode_sel = 2'b01; addr_mode = 1'b0;
        send_frame('{8'h40, 0, 0, 0, 0, 0, 0, 0}, 1, 1'b1, 1'b0, 1'b0);
        expect_q("R11 status only", '{8'h80, 0, 0, 0, 0, 0, 0, 0}, 1);
    endtask

    task automatic t_idle_mode();
        mode_sel = 2'b00;
        send_frame('{8'hFE, 8'h12, 8'h34, 0, 0, 0, 0, 0}, 3, 1'b1, 1'b0, 1'b0);
        chk("R1 idle no writes", got.size(), 0);
        chk("R1 idle ctrl kept", ctrl_field, 8'h0A);
    endtask

    task automatic t_ext0();
        mode_sel = 2'b11; addr_mode = 1'b0;
        got.delete();
        raw_valid = 1'b1; raw_data = 8'h5A;
        @(posedge clk); #1;
        chk("R7 low after first raw", low_addr, 8'h5A);
        raw_data = 8'hA5;
        @(posedge clk); #1;
        raw_valid = 1'b0;
        chk("R7 low after second raw", low_addr, 8'hA5);
        repeat (2) @(posedge clk); #1;
        chk("R7 no writes", got.size(), 0);
    endtask

    task automatic t_ext1();
        mode_sel = 2'b11; addr_mode = 1'b1;
        got.delete();
        raw_valid = 1'b1; raw_data = 8'hC3;
        @(posedge clk); #1;
        raw_valid = 1'b0;
        chk("R8 fifo_wr", fifo_wr, 1);
        chk("R8 fifo_data", fifo_data, 8'hC3);
        chk("R8 low_addr", low_addr, 8'hC3);
        @(posedge clk); #1;
        chk("R8 one write", got.size(), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_addr_accept();
        t_addr_reject();
        t_tr1_bcast();
        t_tr1_group_abort();
        t_mask();
        t_tr0();
        t_mode_change();
        t_single_byte();
        t_idle_mode();
        t_ext0();
        t_ext1();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule